// File: doc/BRIEF.md
# FEAC Codeword Receiver with Code Queue

This block watches a serial bit stream, one bit for each cycle in which the bit enable is high, for the repeating 16-bit Far-End Alarm and Control codeword. It needs no boundary marker: it tests every bit position for the codeword shape. Once it has a boundary, it checks each following 16-bit window at that boundary. A 6-bit code is accepted only after it has come in three codewords in a row, all identical and error-free. Acceptance raises a detection flag, and the flag drops again after two differing error-free codewords. A separate detector flags an idle line made of all ones.

Each accepted code is written once into a four-entry queue. A read strobe drains the queue, and the head entry is always shown on the read data output. The queue is lossy. A code that arrives while the queue is full is thrown away and a sticky overflow flag is raised, which stays set until the clear strobe is pulsed.

Top module: `feac_rx`

## Requirements
- R1: A codeword is 16 bits, received first to last as: 0, C6, C5, C4, C3, C2, C1, 0, then eight 1s. An accepted code is stored with C1 in bit 0 and C6 in bit 5 of the queue entry.
- R2: The codeword boundary is found at any bit offset of the stream. After that, each later 16-bit window at the boundary is evaluated as one codeword.
- R3: The detection flag rises on the third consecutive error-free codeword carrying the same code, in the same cycle that bit is taken. Exactly one queue write happens for each rise, and further repeats of the detected code write nothing.
- R4: A boundary window that fails any of the ten fixed bits is an errored codeword. It resets the repeat run to zero, and the boundary search restarts at every bit position.
- R5: While detected, two consecutive error-free codewords whose code differs from the detected one clear the flag. A single differing codeword followed by the detected code does not clear it.
- R6: Sixteen consecutive 1s set the idle flag and clear the detection flag in the same cycle. The idle flag stays set until the detection flag next rises, and the two flags are never high together.
- R7: The queue holds four codes in arrival order. rd_data shows the oldest entry while rd_empty is 0, and rd_stb removes that entry.
- R8: A code accepted while the queue holds four entries is discarded and sets ovf_flag. ovf_flag then holds until an ovf_clr pulse, and a new overflow in the same cycle wins over the clear.
- R9: rd_stb while the queue is empty is ignored: the queue contents and their order are unchanged.
- R10: Cycles with bit_en low consume no bit. The value on bit_in during those cycles has no effect.
- R11: After reset the queue is empty and the detection, idle and overflow flags are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial line bit |
| rd_stb | input | 1 | Removes the head entry of the queue |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| rd_data | output | 6 | Head entry of the queue (C1 in bit 0) |
| rd_empty | output | 1 | Queue holds no code |
| ovf_flag | output | 1 | A code was discarded because the queue was full |
| idle_flag | output | 1 | All-ones idle condition is present |
| det_flag | output | 1 | A confirmed code is currently detected |

## Verification
Overflow is the hardest state to reach from the ports. Each queue write needs a fresh detection. A fresh detection needs the previous code released by two differing codewords, and then a new code confirmed three times. The directed stimulus chains five distinct codes in triples, so each triple releases the code before it and confirms its own. The fifth confirmation then meets a full queue. The idle case is also subtle, because the eight trailing 1s of the last codeword count toward the sixteen-bit run. The bench therefore checks the exact bit where idle fires, and random segments mix idle runs, errored codewords and bit_en gaps against a bench model.

// File: rtl/feac_rx_pkg.sv
package feac_rx_pkg;

   localparam int CW_LEN = 16;
   localparam int CODE_W = 6;

   typedef logic [CODE_W-1:0] code_t;
   typedef logic [CW_LEN-1:0] window_t;

   // Oldest bit sits in bit 15: 0, C6..C1, 0, eight ones.
   function automatic logic cw_shape_ok(input window_t w);
      return (w[15] == 1'b0) && (w[8] == 1'b0) && (w[7:0] == 8'hFF);
   endfunction

   // C1 lands in bit 0 and C6 in bit 5.
   function automatic code_t cw_code(input window_t w);
      return w[14:9];
   endfunction

endpackage

// File: rtl/feac_window.sv
module feac_window
   import feac_rx_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bit_en,
   input  logic  bit_in,
   output logic  win_match,
   output code_t win_code
);

   window_t hist_q;
   window_t hist_nxt;

   assign hist_nxt  = {hist_q[CW_LEN-2:0], bit_in};
   assign win_match = cw_shape_ok(hist_nxt);
   assign win_code  = cw_code(hist_nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (bit_en) begin
         hist_q <= hist_nxt;
      end
   end

endmodule

// File: rtl/feac_qualify.sv
module feac_qualify
   import feac_rx_pkg::*;
#(
   parameter int CONFIRM  = 3,
   parameter int RELEASE  = 2,
   parameter int IDLE_RUN = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bit_en,
   input  logic  bit_in,
   input  logic  win_match,
   input  code_t win_code,
   output logic  det,
   output logic  idle,
   output logic  wr_en,
   output code_t wr_code
);

   localparam int RUN_W = $clog2(CONFIRM + 1);
   localparam int DIF_W = $clog2(RELEASE + 1);
   localparam int ONE_W = $clog2(IDLE_RUN + 1);
   localparam int PH_W  = $clog2(CW_LEN);

   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(CONFIRM);
   localparam logic [RUN_W-1:0] RUN_ARM = RUN_W'(CONFIRM - 1);
   localparam logic [DIF_W-1:0] DIF_ARM = DIF_W'(RELEASE - 1);
   localparam logic [ONE_W-1:0] ONE_MAX = ONE_W'(IDLE_RUN);
   localparam logic [ONE_W-1:0] ONE_ARM = ONE_W'(IDLE_RUN - 1);
   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(CW_LEN - 1);

   logic             locked_q;
   logic [PH_W-1:0]  phase_q;
   code_t            cand_q;
   logic [RUN_W-1:0] run_q;
   code_t            dcode_q;
   logic [DIF_W-1:0] diff_q;
   logic [ONE_W-1:0] ones_q;
   logic             det_q;
   logic             idle_q;

   logic at_edge, good, bad, again, set_ev, rel_ev, idle_ev;

   always_comb begin
      at_edge = bit_en && (locked_q ? (phase_q == PH_LAST) : win_match);
      good    = at_edge && win_match;
      bad     = at_edge && !win_match;
      again   = good && locked_q && (win_code == cand_q);
      set_ev  = again && (run_q == RUN_ARM) && !det_q;
      rel_ev  = good && det_q && (win_code != dcode_q) && (diff_q == DIF_ARM);
      idle_ev = bit_en && bit_in && (ones_q == ONE_ARM);
   end

   // Boundary tracking and repeat run
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         phase_q  <= '0;
         cand_q   <= '0;
         run_q    <= '0;
      end else if (bit_en) begin
         if (good) begin
            locked_q <= 1'b1;
            phase_q  <= '0;
            if (again) begin
               run_q <= (run_q == RUN_MAX) ? run_q : run_q + RUN_W'(1);
            end else begin
               cand_q <= win_code;
               run_q  <= RUN_W'(1);
            end
         end else if (bad) begin
            locked_q <= 1'b0;
            phase_q  <= '0;
            run_q    <= '0;
         end else if (locked_q) begin
            phase_q <= phase_q + PH_W'(1);
         end
      end
   end

   // All-ones run length
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (bit_en) begin
         if (!bit_in)                ones_q <= '0;
         else if (ones_q != ONE_MAX) ones_q <= ones_q + ONE_W'(1);
      end
   end

   // Detection, release hysteresis and idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det_q   <= 1'b0;
         dcode_q <= '0;
         diff_q  <= '0;
         idle_q  <= 1'b0;
      end else begin
         if (set_ev) begin
            det_q   <= 1'b1;
            dcode_q <= win_code;
         end else if (rel_ev || idle_ev) begin
            det_q <= 1'b0;
         end

         if (set_ev || rel_ev || idle_ev) begin
            diff_q <= '0;
         end else if (good && det_q) begin
            diff_q <= (win_code != dcode_q) ? diff_q + DIF_W'(1) : '0;
         end

         if (idle_ev)     idle_q <= 1'b1;
         else if (set_ev) idle_q <= 1'b0;
      end
   end

   assign det     = det_q;
   assign idle    = idle_q;
   assign wr_en   = set_ev;
   assign wr_code = win_code;

endmodule

// File: rtl/feac_code_fifo.sv
module feac_code_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 6,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop_req,
   input  logic         ovf_clr,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full,
   output logic         ovf,
   output logic [AW:0]  level
);

   localparam logic [AW:0] LVL_FULL = (AW + 1)'(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wr_ptr_q, rd_ptr_q;
   logic         do_push, do_pop;

   assign level   = wr_ptr_q - rd_ptr_q;
   assign full    = (level == LVL_FULL);
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop_req && !empty;
   assign head    = mem[rd_ptr_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr_q[AW-1:0]] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         ovf      <= 1'b0;
      end else begin
         if (do_push) wr_ptr_q <= wr_ptr_q + (AW + 1)'(1);
         if (do_pop)  rd_ptr_q <= rd_ptr_q + (AW + 1)'(1);
         if (push && full) ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
      end
   end

endmodule

// File: rtl/feac_rx.sv
module feac_rx
   import feac_rx_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter int CONFIRM    = 3,
   parameter int RELEASE    = 2,
   parameter int IDLE_RUN   = 16,
   localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bit_en,
   input  logic        bit_in,
   input  logic        rd_stb,
   input  logic        ovf_clr,
   output logic [5:0]  rd_data,
   output logic        rd_empty,
   output logic        ovf_flag,
   output logic        idle_flag,
   output logic        det_flag
);

   generate
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two, at least 2");
      end
      if (CONFIRM < 2) begin : g_bad_confirm
         $error("CONFIRM must be at least 2");
      end
      if (RELEASE < 1 || RELEASE >= CONFIRM) begin : g_bad_release
         $error("RELEASE must lie in 1..CONFIRM-1");
      end
      if (IDLE_RUN <= 8) begin : g_bad_idle
         $error("IDLE_RUN must exceed the codeword ones tail");
      end
   endgenerate

   logic             win_match;
   code_t            win_code;
   logic             code_wr;
   code_t            code_val;
   logic             q_full;
   logic [LVL_W-1:0] q_level;

   feac_window u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .bit_in    (bit_in),
      .win_match (win_match),
      .win_code  (win_code)
   );

   feac_qualify #(
      .CONFIRM  (CONFIRM),
      .RELEASE  (RELEASE),
      .IDLE_RUN (IDLE_RUN)
   ) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .bit_in    (bit_in),
      .win_match (win_match),
      .win_code  (win_code),
      .det       (det_flag),
      .idle      (idle_flag),
      .wr_en     (code_wr),
      .wr_code   (code_val)
   );

   feac_code_fifo #(
      .DEPTH (FIFO_DEPTH),
      .W     (CODE_W)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (code_wr),
      .push_data (code_val),
      .pop_req   (rd_stb),
      .ovf_clr   (ovf_clr),
      .head      (rd_data),
      .empty     (rd_empty),
      .full      (q_full),
      .ovf       (ovf_flag),
      .level     (q_level)
   );

endmodule

// File: rtl/feac_rx_chk.sv
module feac_rx_chk #(
   parameter int DEPTH = 4,
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             det_flag,
   input logic             idle_flag,
   input logic             rd_empty,
   input logic             ovf_flag,
   input logic             rd_stb,
   input logic             ovf_clr,
   input logic             code_wr,
   input logic             q_full,
   input logic [LVL_W-1:0] q_level
);

   assert_det_idle_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(det_flag && idle_flag));

   assert_idle_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_flag) |-> det_flag);

   assert_det_rise_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(det_flag) |-> $past(code_wr));

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(code_wr && q_full));

   assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_empty && !code_wr) |=> rd_empty);

   assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q_level <= LVL_W'(DEPTH));

endmodule

bind feac_rx feac_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .det_flag  (det_flag),
   .idle_flag (idle_flag),
   .rd_empty  (rd_empty),
   .ovf_flag  (ovf_flag),
   .rd_stb    (rd_stb),
   .ovf_clr   (ovf_clr),
   .code_wr   (code_wr),
   .q_full    (q_full),
   .q_level   (q_level)
);

// File: tb/feac_rx_tb.sv
module feac_rx_tb;

   localparam int CLK_PERIOD = 10;

   localparam logic [5:0] CA = 6'b101100;
   localparam logic [5:0] CB = 6'b010011;
   localparam logic [5:0] CC = 6'b110001;
   localparam logic [5:0] CD = 6'b001110;
   localparam logic [5:0] CE = 6'b011010;
   localparam logic [5:0] CF = 6'b100101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, bit_in = 1'b0, rd_stb = 1'b0, ovf_clr = 1'b0;
   logic [5:0] rd_data;
   logic rd_empty, ovf_flag, idle_flag, det_flag;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   feac_rx u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .rd_stb(rd_stb), .ovf_clr(ovf_clr), .rd_data(rd_data),
      .rd_empty(rd_empty), .ovf_flag(ovf_flag), .idle_flag(idle_flag),
      .det_flag(det_flag)
   );

   // ---------------- bench model of the requirements ----------------
   logic [15:0] m_hist;
   bit          m_lock;
   int          m_ph, m_run, m_diff, m_ones;
   logic [5:0]  m_cand, m_dcode;
   bit          m_det, m_idle, m_ovf;
   logic [5:0]  m_q[$];

   function automatic void model_reset();
      m_hist = '0; m_lock = 0; m_ph = 0; m_run = 0; m_diff = 0; m_ones = 0;
      m_cand = '0; m_dcode = '0; m_det = 0; m_idle = 0; m_ovf = 0;
      m_q.delete();
   endfunction

   function automatic void model_step(bit en, bit b, bit rd, bit clr);
      bit wr = 0;
      logic [5:0] wcode = '0;
      int pre = m_q.size();
      if (en) begin
         logic [15:0] w = {m_hist[14:0], b};
         bit ok = (w[15] == 0) && (w[8] == 0) && (w[7:0] == 8'hFF);
         logic [5:0] cd = w[14:9];
         bit bnd = m_lock ? (m_ph == 15) : ok;
         if (bnd && ok) begin
            if (m_lock && cd == m_cand) begin
               if (m_run == 2 && !m_det) begin
                  m_det = 1; m_dcode = cd; wr = 1; wcode = cd; m_diff = 0; m_idle = 0;
               end else if (m_det) begin
                  m_diff = (cd != m_dcode) ? m_diff + 1 : 0;
               end
               if (m_run < 3) m_run++;
            end else begin
               if (m_det) m_diff = (cd != m_dcode) ? m_diff + 1 : 0;
               m_cand = cd; m_run = 1;
            end
            if (m_det && m_diff == 2) begin m_det = 0; m_diff = 0; end
            m_lock = 1; m_ph = 0;
         end else if (bnd) begin
            m_lock = 0; m_ph = 0; m_run = 0;
         end else if (m_lock) begin
            m_ph++;
         end
         if (b) begin
            if (m_ones == 15) begin m_idle = 1; m_det = 0; m_diff = 0; end
            if (m_ones < 16) m_ones++;
         end else m_ones = 0;
         m_hist = w;
      end
      if (clr) m_ovf = 0;
      if (wr) begin
         if (pre == 4) m_ovf = 1;
         else m_q.push_back(wcode);
      end
      if (rd && pre > 0) void'(m_q.pop_front());
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input bit en, input bit b, input bit rd, input bit clr);
      bit_en = en; bit_in = b; rd_stb = rd; ovf_clr = clr;
      @(posedge clk);
      model_step(en, b, rd, clr);
      #1;
      bit_en = 0; rd_stb = 0; ovf_clr = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; bit_en = 0; bit_in = 0; rd_stb = 0; ovf_clr = 0;
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
   endtask

   // C6 first, C1 last; corrupt flips the final fixed one
   task automatic send_cw(input logic [5:0] c, input bit corrupt, input int gap);
      logic [15:0] w = {1'b0, c, 1'b0, 8'hFF};
      if (corrupt) w[0] = 1'b0;
      for (int i = 15; i >= 0; i--) begin
         tick(1, w[i], 0, 0);
         for (int g = 0; g < gap; g++) tick(0, ~w[i], 0, 0);
      end
   endtask

   task automatic rd_pop(); tick(0, 0, 1, 0); endtask

   task automatic cmp_model();
      chk("R3 det", det_flag, m_det);
      chk("R6 idle", idle_flag, m_idle);
      chk("R7 empty", rd_empty, (m_q.size() == 0));
      chk("R8 ovf", ovf_flag, m_ovf);
      if (m_q.size() != 0) chk("R7 head", rd_data, m_q[0]);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd20240607));
      do_reset();

      // R11 reset state
      chk("R11 empty", rd_empty, 1);
      chk("R11 det", det_flag, 0);
      chk("R11 idle", idle_flag, 0);
      chk("R11 ovf", ovf_flag, 0);

      // R2 odd offset, R1 bit order, R3 three repeats
      tick(1, 1, 0, 0); tick(1, 0, 0, 0); tick(1, 1, 0, 0);
      send_cw(CA, 0, 0); send_cw(CA, 0, 0);
      chk("R3 no det after two", det_flag, 0);
      send_cw(CA, 0, 0);
      chk("R3 det after three", det_flag, 1);
      chk("R1 code mapping", rd_data, CA);
      send_cw(CA, 0, 0);
      rd_pop();
      chk("R3 single write", rd_empty, 1);

      // R5 hysteresis
      send_cw(CB, 0, 0);
      chk("R5 one differing keeps", det_flag, 1);
      send_cw(CA, 0, 0);
      send_cw(CB, 0, 0);
      chk("R5 non-consecutive keeps", det_flag, 1);
      send_cw(CB, 0, 0);
      chk("R5 two differing clear", det_flag, 0);

      // R4 errored codeword breaks the run
      do_reset();
      send_cw(CA, 0, 0); send_cw(CA, 0, 0); send_cw(CA, 1, 0); send_cw(CA, 0, 0);
      chk("R4 errored resets run", det_flag, 0);
      send_cw(CA, 0, 0); send_cw(CA, 0, 0);
      chk("R4 reacquire", det_flag, 1);

      // R6 idle counts the codeword ones tail
      for (int i = 0; i < 7; i++) tick(1, 1, 0, 0);
      chk("R6 fifteen ones", idle_flag, 0);
      tick(1, 1, 0, 0);
      chk("R6 sixteen ones idle", idle_flag, 1);
      chk("R6 idle clears det", det_flag, 0);
      send_cw(CA, 0, 0); send_cw(CA, 0, 0);
      chk("R6 idle holds", idle_flag, 1);
      send_cw(CA, 0, 0);
      chk("R6 idle ends on det", idle_flag, 0);
      chk("R6 det set", det_flag, 1);

      // R10 gaps with inverted bit_in
      do_reset();
      send_cw(CC, 0, 2); send_cw(CC, 0, 1); send_cw(CC, 0, 3);
      chk("R10 gaps ignored det", det_flag, 1);
      chk("R10 gaps ignored code", rd_data, CC);

      // R8 overflow, R7 order, R9 empty read
      do_reset();
      for (int i = 0; i < 3; i++) send_cw(CA, 0, 0);
      for (int i = 0; i < 3; i++) send_cw(CB, 0, 0);
      for (int i = 0; i < 3; i++) send_cw(CC, 0, 0);
      for (int i = 0; i < 3; i++) send_cw(CD, 0, 0);
      send_cw(CE, 0, 0); send_cw(CE, 0, 0);
      chk("R8 no ovf yet", ovf_flag, 0);
      send_cw(CE, 0, 0);
      chk("R8 ovf set", ovf_flag, 1);
      chk("R7 head A", rd_data, CA); rd_pop();
      chk("R7 head B", rd_data, CB); rd_pop();
      chk("R7 head C", rd_data, CC); rd_pop();
      chk("R8 E dropped head D", rd_data, CD); rd_pop();
      chk("R7 drained", rd_empty, 1);
      rd_pop();
      chk("R9 empty read", rd_empty, 1);
      for (int i = 0; i < 3; i++) send_cw(CF, 0, 0);
      chk("R9 pointers intact", rd_data, CF);
      chk("R9 one entry", rd_empty, 0);
      chk("R8 sticky", ovf_flag, 1);
      tick(0, 0, 0, 1);
      chk("R8 clear", ovf_flag, 0);

      // Random segments against the model
      do_reset();
      for (int s = 0; s < 300; s++) begin
         int kind = $urandom % 10;
         logic [15:0] w;
         int nb;
         if (kind < 7) begin
            logic [5:0] c = (($urandom % 3) == 0) ? CB : ((($urandom % 2) == 0) ? CA : CD);
            w = {1'b0, c, 1'b0, 8'hFF};
            if (kind == 6) w[$urandom % 16] ^= 1'b1;
            nb = 16;
         end else if (kind == 7) begin
            w = 16'hFFFF; nb = 5 + ($urandom % 12);
         end else begin
            w = 16'($urandom); nb = 1 + ($urandom % 8);
         end
         for (int i = nb - 1; i >= 0; i--) begin
            while (($urandom % 6) == 0) begin
               tick(0, $urandom % 2, ($urandom % 8) == 0, ($urandom % 50) == 0);
               cmp_model();
            end
            tick(1, w[i], ($urandom % 12) == 0, ($urandom % 50) == 0);
            cmp_model();
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule